// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the slave-side front end of a serial, page-organised flash device. It watches the serial clock, the active-low chip select and the serial input. Each frame starts with an 8-bit opcode. The block decodes that opcode into a compact command code. For commands that carry an address it collects 24 address bits and splits them into a page address and a byte or buffer address, in the way the command class requires. It then counts any don't-care bits the command needs and pulses a data-phase strobe at the point where data transfer begins.

On read-type commands the block drives the serial output, which changes after falling clock edges. The status byte comes from an input. Read bytes come from an input as well, and a take pulse asks the next stage for the following byte. On write-type commands it passes each received byte out on a valid/data pair. For commands that modify the array, nothing happens at the end of the address: a commit pulse is issued when chip select rises, and only if the address phase completed. The array, the buffer storage and the self-timed operations sit outside this block.

The block is clocked by a system clock that is faster than the serial clock. The serial pins pass through two-stage synchronisers and the block acts on detected edges.

Top module: `sflash_cmd_front`

## Requirements
- R1: A frame begins only at a detected falling edge of `cs_n`. Serial input bits are sampled on rising `sck` edges, MSB first. Edges of `sck` while `cs_n` is high have no effect. Both idle clock levels (low or high at the falling edge of `cs_n`) decode the same way.
- R2: The 8-bit opcode sets `cmd_code`, and the code is cleared to 0 at each frame start:
  - 57h or D7h gives 1 (status).
  - 68h or E8h gives 2 (continuous read).
  - 52h or D2h gives 3 (page read).
  - 54h or D4h gives 4 (buffer read).
  - 84h gives 5 (buffer write).
  - 83h gives 6 (program with erase).
  - 88h gives 7 (program without erase).
  - 81h gives 8 (page erase).
  - 50h gives 9 (block erase).
  - 82h gives 10 (write-and-program).
  - 53h gives 11 (transfer).
  - 60h gives 12 (compare).
  - 58h gives 13 (rewrite).
  - Every other value gives 0.
- R3: For memory commands the 24-bit address is split into bits 23..18 (reserved), bits 17..9 (`page_addr`) and bits 8..0 (byte address). Reads and code 10 present the byte field on `byte_addr`. Codes 6, 7, 8, 11, 12 and 13 present `byte_addr` = 0.
- R4: Buffer commands (codes 4 and 5) take `byte_addr` from address bits 8..0 and set `page_addr` to 0.
- R5: Block erase sets `page_addr` to address bits 17..12 followed by three zero bits, and sets `byte_addr` to 0.
- R6: `data_start` pulses once per frame at these points:
  - Status: after the last opcode bit.
  - Codes 5 and 10: after the last address bit.
  - Codes 2 and 3: after 32 further don't-care bits.
  - Code 4: after 8 further don't-care bits.
  - Other codes: never.
- R7: `commit` pulses once, on the rising edge of `cs_n`, for codes 6 to 13 only.
- R8: An unrecognised opcode leaves `page_addr` and `byte_addr` unchanged. It produces no `data_start`, `commit` or `wr_valid` for the rest of the frame.
- R9: If `cs_n` rises before all 24 address bits have arrived, no `commit` is issued.
- R10: `so_oe` is low whenever `cs_n` is high (after synchronisation) and is high during a read data phase. `so` presents each byte MSB first, changing after falling `sck` edges. A status read repeats `status_in` every 8 bits.
- R11: During codes 2, 3 and 4, each byte shifted out is `rd_data` captured at the byte boundary. The capture is marked by a one-cycle `rd_take` pulse. Status reads give no `rd_take`.
- R12: During codes 5 and 10, each 8 data bits after the address produce one `wr_valid` pulse, with the byte (first bit as MSB) on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| status_in | input | 8 | Status byte shifted out on status reads |
| rd_data | input | 8 | Next read byte from the data source |
| rd_take | output | 1 | rd_data has been captured |
| cmd_code | output | 4 | Decoded command class |
| page_addr | output | PAGE_W | Decoded page address |
| byte_addr | output | BYTE_W | Decoded byte or buffer address |
| data_start | output | 1 | Data phase begins |
| commit | output | 1 | Array operation confirmed at frame end |
| wr_valid | output | 1 | Write byte valid |
| wr_data | output | 8 | Write byte |

## Verification
The bench builds the block with its defaults: 6 reserved, 9 page and 9 byte address bits, 32 don't-care bits for array reads and 8 for buffer reads. With these values a full sweep of all 256 opcode values is affordable. Each opcode gets its own address pattern, and the idle clock level alternates between opcodes, so every decode, address split, commit decision and silent frame is checked. The small dummy counts also let directed frames probe the exact bit on which the data phase opens, by stopping one bit short and then adding one more.

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front #(
  parameter int RSV_W     = 6,
  parameter int PAGE_W    = 9,
  parameter int BYTE_W    = 9,
  parameter int RD_DUMMY  = 32,
  parameter int BUF_DUMMY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [7:0]        status_in,
  input  logic [7:0]        rd_data,
  output logic              rd_take,
  output logic [3:0]        cmd_code,
  output logic [PAGE_W-1:0] page_addr,
  output logic [BYTE_W-1:0] byte_addr,
  output logic              data_start,
  output logic              commit,
  output logic              wr_valid,
  output logic [7:0]        wr_data
);

  localparam int ADDR_W  = RSV_W + PAGE_W + BYTE_W;
  localparam int CNT_MAX = (ADDR_W > RD_DUMMY) ? ADDR_W : RD_DUMMY;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [3:0] C_NONE = 4'd0,  C_STAT = 4'd1,  C_CONT = 4'd2,  C_PGRD = 4'd3;
  localparam logic [3:0] C_BFRD = 4'd4,  C_BFWR = 4'd5,  C_PGME = 4'd6,  C_PGMN = 4'd7;
  localparam logic [3:0] C_PGER = 4'd8,  C_BKER = 4'd9,  C_WRPG = 4'd10, C_XFER = 4'd11;
  localparam logic [3:0] C_CMPR = 4'd12, C_RWRT = 4'd13;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_DATA, S_HOLD, S_SKIP} st_t;
  st_t st;

  function automatic logic [3:0] classify(input logic [7:0] op);
    case (op)
      8'h57, 8'hD7: classify = C_STAT;
      8'h68, 8'hE8: classify = C_CONT;
      8'h52, 8'hD2: classify = C_PGRD;
      8'h54, 8'hD4: classify = C_BFRD;
      8'h84:        classify = C_BFWR;
      8'h83:        classify = C_PGME;
      8'h88:        classify = C_PGMN;
      8'h81:        classify = C_PGER;
      8'h50:        classify = C_BKER;
      8'h82:        classify = C_WRPG;
      8'h53:        classify = C_XFER;
      8'h60:        classify = C_CMPR;
      8'h58:        classify = C_RWRT;
      default:      classify = C_NONE;
    endcase
  endfunction

  logic [2:0]        sck_s, cs_s;
  logic [1:0]        si_s;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  logic [2:0]        ocnt;
  logic [7:0]        osh;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sck_fall = ~sck_s[1] & sck_s[2];
  wire cs_fall  = ~cs_s[1] & cs_s[2];
  wire cs_rise  = cs_s[1] & ~cs_s[2];

  wire [ADDR_W-1:0] sh_nx   = {sh[ADDR_W-2:0], si_s[1]};
  wire [3:0]        op_cls  = classify(sh_nx[7:0]);
  wire [PAGE_W-1:0] pg_fld  = sh_nx[BYTE_W +: PAGE_W];
  wire [BYTE_W-1:0] by_fld  = sh_nx[BYTE_W-1:0];

  wire is_rd  = (cmd_code == C_STAT) || (cmd_code == C_CONT) ||
                (cmd_code == C_PGRD) || (cmd_code == C_BFRD);
  wire is_wr  = (cmd_code == C_BFWR) || (cmd_code == C_WRPG);
  wire is_arr = (cmd_code >= C_PGME) && (cmd_code <= C_RWRT);
  wire [CNT_W-1:0] dummy_last = (cmd_code == C_BFRD) ? CNT_W'(BUF_DUMMY - 1)
                                                      : CNT_W'(RD_DUMMY - 1);
  wire [7:0] out_byte = (cmd_code == C_STAT) ? status_in : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; cs_s <= '1; si_s <= '0;
      st <= S_IDLE; cnt <= '0; sh <= '0; ocnt <= '0; osh <= '0;
      so <= 1'b0; so_oe <= 1'b0; rd_take <= 1'b0;
      cmd_code <= C_NONE; page_addr <= '0; byte_addr <= '0;
      data_start <= 1'b0; commit <= 1'b0; wr_valid <= 1'b0; wr_data <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s  <= {cs_s[1:0], cs_n};
      si_s  <= {si_s[0], si};
      data_start <= 1'b0; commit <= 1'b0; wr_valid <= 1'b0; rd_take <= 1'b0;
      if (cs_rise) begin
        if (st == S_HOLD || (st == S_DATA && cmd_code == C_WRPG)) commit <= 1'b1;
        st <= S_IDLE; so_oe <= 1'b0;
      end else if (cs_fall) begin
        st <= S_OPC; cnt <= '0; sh <= '0; ocnt <= '0;
        cmd_code <= C_NONE; so_oe <= 1'b0;
      end else if (sck_rise) begin
        case (st)
          S_OPC: begin
            sh <= sh_nx; cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(7)) begin
              cnt <= '0; cmd_code <= op_cls;
              if (op_cls == C_STAT) begin
                st <= S_DATA; data_start <= 1'b1;
              end else if (op_cls == C_NONE) st <= S_SKIP;
              else st <= S_ADDR;
            end
          end
          S_ADDR: begin
            sh <= sh_nx; cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              case (cmd_code)
                C_BFRD, C_BFWR: begin page_addr <= '0; byte_addr <= by_fld; end
                C_BKER: begin
                  page_addr <= {pg_fld[PAGE_W-1:3], 3'b000}; byte_addr <= '0;
                end
                C_CONT, C_PGRD, C_WRPG: begin page_addr <= pg_fld; byte_addr <= by_fld; end
                default: begin page_addr <= pg_fld; byte_addr <= '0; end
              endcase
              if (cmd_code == C_CONT || cmd_code == C_PGRD || cmd_code == C_BFRD)
                st <= S_DUMMY;
              else if (is_wr) begin
                st <= S_DATA; data_start <= 1'b1;
              end else st <= S_HOLD;
            end
          end
          S_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == dummy_last) begin
              cnt <= '0; st <= S_DATA; data_start <= 1'b1;
            end
          end
          S_DATA: if (is_wr) begin
            sh <= sh_nx; cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(7)) begin
              cnt <= '0; wr_valid <= 1'b1; wr_data <= sh_nx[7:0];
            end
          end
          default: ;
        endcase
      end else if (sck_fall && st == S_DATA && is_rd) begin
        so_oe <= 1'b1;
        ocnt  <= ocnt + 1'b1;
        if (ocnt == 3'd0) begin
          so <= out_byte[7]; osh <= {out_byte[6:0], 1'b0};
          rd_take <= (cmd_code != C_STAT);
        end else begin
          so <= osh[7]; osh <= {osh[6:0], 1'b0};
        end
      end
    end
  end

  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s[2] |-> !so_oe);
  p_commit_arr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cs_s[2] && is_arr));
  p_skip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |=> (!data_start && !wr_valid && !commit));
  p_start_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |=> !data_start);
  p_wr_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  p_take_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> (so_oe && cmd_code != C_STAT));
  p_block_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_code == C_BKER) |-> (page_addr[2:0] == 3'b000));

endmodule

// File: tb/sflash_cmd_front_test.sv
module sflash_cmd_front_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0;
  logic so, so_oe, rd_take, data_start, commit, wr_valid;
  logic [7:0] status_in = 8'hAC, rd_data, wr_data;
  logic [3:0] cmd_code;
  logic [8:0] page_addr, byte_addr;

  int checks = 0, errors = 0;
  int commits = 0, starts = 0, takes = 0, wrs = 0;
  logic [7:0] wr_log [16];
  bit timed_out = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rd_data = 8'h3C + 8'(takes * 17);

  sflash_cmd_front uut (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .status_in(status_in), .rd_data(rd_data), .rd_take(rd_take),
    .cmd_code(cmd_code), .page_addr(page_addr), .byte_addr(byte_addr),
    .data_start(data_start), .commit(commit), .wr_valid(wr_valid), .wr_data(wr_data));

  always @(posedge clk) begin
    if (commit) commits <= commits + 1;
    if (data_start) starts <= starts + 1;
    if (rd_take) takes <= takes + 1;
    if (wr_valid) begin wr_log[wrs % 16] <= wr_data; wrs <= wrs + 1; end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b);
    sck = 0; si = b; tick(HALF); sck = 1; tick(HALF);
  endtask
  task automatic sbits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask
  task automatic fbegin(bit m3);
    sck = m3; cs_n = 1; tick(4); cs_n = 0; tick(HALF);
  endtask
  task automatic fend(bit m3);
    if (!m3) begin sck = 0; tick(HALF); end
    cs_n = 1; tick(8);
  endtask
  task automatic rbyte(output logic [7:0] v, output bit oe_all);
    v = 0; oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      sck = 0; tick(HALF); v = {v[6:0], so}; oe_all &= so_oe; sck = 1; tick(HALF);
    end
  endtask

  function automatic int ecode(logic [7:0] op);
    case (op)
      8'h57, 8'hD7: return 1;  8'h68, 8'hE8: return 2;
      8'h52, 8'hD2: return 3;  8'h54, 8'hD4: return 4;
      8'h84: return 5;  8'h83: return 6;  8'h88: return 7;  8'h81: return 8;
      8'h50: return 9;  8'h82: return 10; 8'h53: return 11; 8'h60: return 12;
      8'h58: return 13; default: return 0;
    endcase
  endfunction

  task automatic sweep();
    for (int op = 0; op < 256; op++) begin
      logic [23:0] a = 24'(op * 40503 + 4951);
      int c = ecode(8'(op));
      int c0 = commits, d0 = starts, w0 = wrs;
      logic [8:0] pg0 = page_addr, by0 = byte_addr;
      int ep, eb;
      fbegin(op[0]);
      sbits(32'(op), 8);
      if (c != 1) sbits(32'(a), 24);
      fend(op[0]);
      chk(cmd_code == 4'(c), "R2 R1 decode", cmd_code, c);
      chk(wrs == w0, "R12 no write bytes", wrs - w0, 0);
      if (c == 0) begin
        chk(page_addr == pg0 && byte_addr == by0, "R8 address unchanged",
            {page_addr, byte_addr}, {pg0, by0});
        chk(starts == d0 && commits == c0, "R8 no strobes", starts - d0 + commits - c0, 0);
      end else if (c != 1) begin
        ep = (c == 4 || c == 5) ? 0 : (c == 9) ? int'({a[17:12], 3'b000}) : int'(a[17:9]);
        eb = (c == 2 || c == 3 || c == 4 || c == 5 || c == 10) ? int'(a[8:0]) : 0;
        chk(page_addr == 9'(ep), "R3 R4 R5 page", page_addr, ep);
        chk(byte_addr == 9'(eb), "R3 R4 R5 byte", byte_addr, eb);
        chk(commits - c0 == ((c >= 6) ? 1 : 0), "R7 commit", commits - c0, (c >= 6) ? 1 : 0);
        chk(starts - d0 == ((c == 5 || c == 10) ? 1 : 0), "R6 start", starts - d0,
            (c == 5 || c == 10) ? 1 : 0);
      end else begin
        chk(starts - d0 == 1, "R6 status start", starts - d0, 1);
      end
    end
  endtask

  task automatic run_all();
    logic [7:0] v; bit oe; int c0, d0, w0, t0;
    tick(5); rst_n = 1; tick(5);
    chk(so_oe == 0 && cmd_code == 0 && commit == 0 && data_start == 0,
        "R10 reset state", {so_oe, cmd_code}, 0);

    d0 = starts;
    for (int i = 0; i < 8; i++) sbit(1'(8'h57 >> (7 - i)));
    tick(8);
    chk(starts == d0 && cmd_code == 0 && so_oe == 0, "R1 cs high ignored", starts - d0, 0);

    sweep();

    d0 = starts; t0 = takes;
    fbegin(0); sbits(32'hD2, 8); sbits(32'h00_2A_05, 24); sbits(0, 31);
    chk(starts == d0, "R6 page read 31 dummy", starts - d0, 0);
    sbit(0);
    chk(starts == d0 + 1, "R6 page read 32 dummy", starts - d0, 1);
    for (int k = 0; k < 3; k++) begin
      rbyte(v, oe);
      chk(v == 8'(8'h3C + 17 * (t0 + k)), "R11 read byte", v, 8'(8'h3C + 17 * (t0 + k)));
      chk(oe, "R10 oe in read", oe, 1);
    end
    chk(takes == t0 + 3, "R11 take count", takes - t0, 3);
    fend(0);
    chk(so_oe == 0, "R10 oe off after frame", so_oe, 0);

    t0 = takes;
    fbegin(1); sbits(32'hD7, 8);
    for (int k = 0; k < 2; k++) begin
      rbyte(v, oe);
      chk(v == 8'hAC && oe, "R10 status repeat", v, 8'hAC);
    end
    chk(takes == t0, "R11 no take on status", takes - t0, 0);
    fend(1);

    d0 = starts; t0 = takes;
    fbegin(0); sbits(32'h54, 8); sbits(32'h00_01_07, 24); sbits(0, 7);
    chk(starts == d0 && byte_addr == 9'h107 && page_addr == 0, "R6 R4 buffer read 7 dummy",
        starts - d0, 0);
    sbit(0);
    chk(starts == d0 + 1, "R6 buffer read 8 dummy", starts - d0, 1);
    rbyte(v, oe);
    chk(v == 8'(8'h3C + 17 * t0), "R11 buffer read byte", v, 8'(8'h3C + 17 * t0));
    fend(0);

    c0 = commits; w0 = wrs;
    fbegin(1); sbits(32'h84, 8); sbits(32'h00_00_33, 24);
    sbits(32'h11, 8); sbits(32'hA7, 8); sbits(32'hF0, 8); fend(1);
    chk(wrs == w0 + 3 && commits == c0, "R12 buffer write count", wrs - w0, 3);
    chk(wr_log[(w0) % 16] == 8'h11, "R12 byte0", wr_log[w0 % 16], 8'h11);
    chk(wr_log[(w0 + 1) % 16] == 8'hA7, "R12 byte1", wr_log[(w0 + 1) % 16], 8'hA7);
    chk(wr_log[(w0 + 2) % 16] == 8'hF0, "R12 byte2", wr_log[(w0 + 2) % 16], 8'hF0);

    c0 = commits; w0 = wrs;
    fbegin(0); sbits(32'h82, 8); sbits(32'h00_FF_01, 24);
    sbits(32'h5A, 8); sbits(32'hC3, 8); fend(0);
    chk(wrs == w0 + 2 && wr_log[(w0 + 1) % 16] == 8'hC3, "R12 write-and-program data",
        wrs - w0, 2);
    chk(commits == c0 + 1, "R7 write-and-program commit", commits - c0, 1);

    c0 = commits;
    fbegin(0); sbits(32'h81, 8); sbits(32'h3FF, 10); fend(0);
    chk(commits == c0, "R9 aborted erase", commits - c0, 0);
    fbegin(1); sbits(32'h82, 8); sbits(32'hFFFFFF, 23); fend(1);
    chk(commits == c0, "R9 aborted program", commits - c0, 0);
    chk(so_oe == 0, "R10 oe idle", so_oe, 0);
  endtask

  initial begin
    fork
      run_all();
      begin tick(190000); timed_out = 1; end
    join_any
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule